// File: doc/BRIEF.md
# SDRAM Single-Bank Command Timing Scheduler

This block schedules commands for a single SDRAM bank under an open-row policy. Each request arrives on a valid/ready channel and carries a read/write flag, a row, a column and a tag. The block works out which command the request needs next. A request to the open row needs a column command. A request to a different row while a row is open needs a row close. A request with no row open needs a row open. The block drives that command on a registered command/address bus once every timing window that guards it has expired.

The five timing values arrive on configuration inputs and are held stable while traffic flows. A typical setting is 3/3/3/9/5 cycles for open-to-column, column-read latency, close-to-open, open-to-close and write-to-close. Read returns are tracked in a tagged shift pipeline, so any number of reads can be in flight at once. Each read return raises a strobe carrying the tag of the request that caused it. A configured open-to-close time that is too short to stream out a read is raised to a safe minimum, and a warning flag is set.

Top module: `bank_sched`

## Requirements
- R1: After a synchronous reset the bank has no open row, `cmd_code` is NOP and `rd_valid` is 0. The first command sent for a request is an open-row command (ACT) with the request's row on `cmd_addr`. Command codes: NOP=0, ACT=1, READ=2, WRITE=3, PRE=4. `cmd_addr` carries the row on ACT, the column on READ/WRITE, and zero otherwise.
- R2: A READ or WRITE appears no sooner than `cfg_trcd` cycles after the ACT that opened its row. When a request is already waiting, it appears exactly then.
- R3: A request to the open row gets no PRE or ACT. Requests to the open row that arrive back to back get one column command per cycle. The row stays open while no requests arrive.
- R4: `rd_valid` pulses exactly `cfg_tcas` cycles after each READ appears on `cmd_code`, with `rd_tag` equal to that request's tag. Reads complete in issue order, and several may be outstanding at once.
- R5: A request to a row other than the open row first causes a PRE. The next ACT appears no sooner than `cfg_trp` cycles after that PRE, and exactly then when the request is waiting.
- R6: A PRE appears no sooner than the effective open-to-close time after the ACT of the row it closes.
- R7: A PRE appears no sooner than `cfg_twr` cycles after the last WRITE to the open row.
- R8: The effective open-to-close time is the larger of `cfg_tras` and `cfg_trcd + cfg_tcas + 2`. `cfg_warn` is 1 exactly when `cfg_tras` is below that sum.
- R9: `req_ready` is 1 only in a cycle where the request is turned into a READ or WRITE, and that command appears on the next cycle. While the needed command is blocked by any timing window, or while a PRE or ACT is issued, `req_ready` is 0. At most one command is driven per cycle, and NOP is driven otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_trcd | input | TW | Cycles from ACT to first column command |
| cfg_tcas | input | TW | Cycles from READ to read-return strobe |
| cfg_trp | input | TW | Cycles from PRE to next ACT |
| cfg_tras | input | TW | Requested minimum cycles from ACT to PRE |
| cfg_twr | input | TW | Cycles from last WRITE to PRE |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | RW | Row address of request |
| req_col | input | CW | Column address of request |
| req_tag | input | TAGW | Request tag returned with read data strobe |
| cmd_code | output | 3 | Command issued this cycle |
| cmd_addr | output | max(RW,CW) | Row or column for the command |
| rd_valid | output | 1 | Read data beat valid |
| rd_tag | output | TAGW | Tag of the returning read |
| cfg_warn | output | 1 | Open-to-close setting was raised to the minimum |

## Verification
The hardest case to reach is a row close whose release depends on two windows at once: the open-to-close time and the write recovery time. Which of the two ends last depends on the configuration and on when the last write landed. The stimulus sweeps every combination of small timing values and runs the same request stream each time. That stream is two reads and a write to one row, a conflicting row with a write, then a third row, an idle gap and a row hit. Across the sweep each window becomes the binding one in turn, including settings where the open-to-close value is clamped. The expected issue cycle of every command and read strobe is computed from the settings alone.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } sdb_cmd_e;
endpackage

// File: rtl/sdb_timer.sv
// Down-counting window timer: expired goes high once span cycles
// have elapsed since the cycle whose registered command loaded it.
module sdb_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] span,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (span == '0) ? '0 : span - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdb_rdpipe.sv
// Tagged shift pipeline for read returns; an entry injected at slot
// lat reaches slot 0 (the output) lat cycles after the command shows.
module sdb_rdpipe #(
  parameter int TW   = 4,
  parameter int TAGW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [TAGW-1:0] tag_in,
  input  logic [TW-1:0]   lat,
  output logic            vld_out,
  output logic [TAGW-1:0] tag_out
);
  localparam int D = (1 << TW) - 1;

  logic [D:0]      v_q;
  logic [TAGW-1:0] t_q [0:D];
  logic [D+1:0]    v_sh;
  logic [TAGW-1:0] t_sh [0:D+1];
  logic [TW-1:0]   lat_e;

  assign lat_e = (lat == '0) ? TW'(1) : lat;
  assign v_sh  = {1'b0, v_q};

  always_comb begin
    for (int i = 0; i <= D; i++) t_sh[i] = t_q[i];
    t_sh[D+1] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
    end else begin
      for (int i = 0; i <= D; i++) begin
        v_q[i] <= (push && int'(lat_e) == i) ? 1'b1 : v_sh[i+1];
      end
    end
  end

  // Tag slots carry no reset so they can map onto plain storage.
  always_ff @(posedge clk) begin
    for (int i = 0; i <= D; i++) begin
      t_q[i] <= (push && int'(lat_e) == i) ? tag_in : t_sh[i+1];
    end
  end

  assign vld_out = v_q[0];
  assign tag_out = t_q[0];
endmodule

// File: rtl/bank_sched.sv
module bank_sched
  import sdb_pkg::*;
#(
  parameter int TW   = 4,
  parameter int RW   = 13,
  parameter int CW   = 10,
  parameter int TAGW = 4,
  localparam int AW  = (RW > CW) ? RW : CW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TW-1:0]   cfg_trcd,
  input  logic [TW-1:0]   cfg_tcas,
  input  logic [TW-1:0]   cfg_trp,
  input  logic [TW-1:0]   cfg_tras,
  input  logic [TW-1:0]   cfg_twr,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [RW-1:0]   req_row,
  input  logic [CW-1:0]   req_col,
  input  logic [TAGW-1:0] req_tag,
  output logic [2:0]      cmd_code,
  output logic [AW-1:0]   cmd_addr,
  output logic            rd_valid,
  output logic [TAGW-1:0] rd_tag,
  output logic            cfg_warn
);
  localparam int RASW = TW + 2;

  // Effective open-to-close window (clamped to column + latency + 2).
  logic [RASW-1:0] ras_min, ras_eff;
  logic            ras_short;

  assign ras_min   = RASW'(cfg_trcd) + RASW'(cfg_tcas) + RASW'(2);
  assign ras_short = RASW'(cfg_tras) < ras_min;
  assign ras_eff   = ras_short ? ras_min : RASW'(cfg_tras);

  // Row state
  logic          open_q;
  logic [RW-1:0] row_q;
  logic          row_hit;

  assign row_hit = open_q && (req_row == row_q);

  // Window status
  logic rcd_ok, ras_ok, rp_ok, wr_ok;

  // Next-command decision
  sdb_cmd_e      nxt;
  logic [AW-1:0] nxt_addr;

  always_comb begin
    nxt       = CMD_NOP;
    nxt_addr  = '0;
    req_ready = 1'b0;
    if (req_valid) begin
      if (row_hit) begin
        if (rcd_ok) begin
          nxt       = req_write ? CMD_WR : CMD_RD;
          nxt_addr  = AW'(req_col);
          req_ready = 1'b1;
        end
      end else if (open_q) begin
        if (ras_ok && wr_ok) nxt = CMD_PRE;
      end else if (rp_ok) begin
        nxt      = CMD_ACT;
        nxt_addr = AW'(req_row);
      end
    end
  end

  logic do_act, do_pre, do_wr, do_rd;
  assign do_act = (nxt == CMD_ACT);
  assign do_pre = (nxt == CMD_PRE);
  assign do_wr  = (nxt == CMD_WR);
  assign do_rd  = (nxt == CMD_RD);

  // Registered command bus, row register and warning flag
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_code <= CMD_NOP;
      cmd_addr <= '0;
      open_q   <= 1'b0;
      row_q    <= '0;
      cfg_warn <= 1'b0;
    end else begin
      cmd_code <= nxt;
      cmd_addr <= nxt_addr;
      cfg_warn <= ras_short;
      if (do_act) begin
        open_q <= 1'b1;
        row_q  <= req_row;
      end else if (do_pre) begin
        open_q <= 1'b0;
      end
    end
  end

  // Timing windows
  sdb_timer #(.W(TW)) u_rcd (
    .clk(clk), .rst(rst), .load(do_act), .span(cfg_trcd), .expired(rcd_ok)
  );

  sdb_timer #(.W(RASW)) u_ras (
    .clk(clk), .rst(rst), .load(do_act), .span(ras_eff), .expired(ras_ok)
  );

  sdb_timer #(.W(TW)) u_rp (
    .clk(clk), .rst(rst), .load(do_pre), .span(cfg_trp), .expired(rp_ok)
  );

  sdb_timer #(.W(TW)) u_wr (
    .clk(clk), .rst(rst), .load(do_wr), .span(cfg_twr), .expired(wr_ok)
  );

  // Read return tracking
  sdb_rdpipe #(.TW(TW), .TAGW(TAGW)) u_rdp (
    .clk     (clk),
    .rst     (rst),
    .push    (do_rd),
    .tag_in  (req_tag),
    .lat     (cfg_tcas),
    .vld_out (rd_valid),
    .tag_out (rd_tag)
  );
endmodule

// File: rtl/bank_sched_chk.sv
module bank_sched_chk #(
  parameter int TW = 4,
  parameter int CW = 10,
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst,
  input logic [TW-1:0] cfg_trcd,
  input logic [TW-1:0] cfg_tcas,
  input logic [TW-1:0] cfg_trp,
  input logic [TW-1:0] cfg_tras,
  input logic [TW-1:0] cfg_twr,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [CW-1:0] req_col,
  input logic [2:0]    cmd_code,
  input logic [AW-1:0] cmd_addr,
  input logic          rd_valid
);
  localparam logic [15:0] SAT = 16'hFFFF;

  logic [15:0] since_act, since_pre, since_wr, ras_need;
  logic [7:0]  rd_out;
  logic        row_open;
  logic        is_col;

  assign is_col   = (cmd_code == 3'd2) || (cmd_code == 3'd3);
  assign ras_need = (16'(cfg_tras) > 16'(cfg_trcd) + 16'(cfg_tcas) + 16'd2)
                  ? 16'(cfg_tras) : 16'(cfg_trcd) + 16'(cfg_tcas) + 16'd2;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_act <= SAT;
      since_pre <= SAT;
      since_wr  <= SAT;
      row_open  <= 1'b0;
      rd_out    <= '0;
    end else begin
      since_act <= (cmd_code == 3'd1) ? 16'd1 : (since_act == SAT ? SAT : since_act + 16'd1);
      since_pre <= (cmd_code == 3'd4) ? 16'd1 : (since_pre == SAT ? SAT : since_pre + 16'd1);
      since_wr  <= (cmd_code == 3'd3) ? 16'd1 : (since_wr  == SAT ? SAT : since_wr  + 16'd1);
      if (cmd_code == 3'd1) row_open <= 1'b1;
      else if (cmd_code == 3'd4) row_open <= 1'b0;
      rd_out <= rd_out + 8'((cmd_code == 3'd2) ? 1 : 0) - 8'(rd_valid ? 1 : 0);
    end
  end

  // R1: ACT only with no row open; column and PRE only with one open
  p_act_closed_r1: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == 3'd1) |-> !row_open);
  p_use_open_r1: assert property (@(posedge clk) disable iff (rst)
    (is_col || cmd_code == 3'd4) |-> row_open);
  p_no_bad_code_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_code <= 3'd4);

  // R2
  p_col_after_act_r2: assert property (@(posedge clk) disable iff (rst)
    is_col |-> (since_act >= 16'(cfg_trcd)));

  // R4: a read strobe always has a READ behind it
  p_rd_has_src_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_out != 8'd0));

  // R5
  p_act_after_pre_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == 3'd1) |-> (since_pre >= 16'(cfg_trp)));

  // R6
  p_pre_after_ras_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == 3'd4) |-> (since_act >= ras_need));

  // R7
  p_pre_after_wr_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == 3'd4) |-> (since_wr >= 16'(cfg_twr)));

  // R8: the clamp floor holds whatever cfg_tras says
  p_pre_floor_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == 3'd4) |-> (since_act >= 16'(cfg_trcd) + 16'(cfg_tcas) + 16'd2));

  // R9: acceptance yields the matching column command next cycle
  p_accept_rd_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write) |=> (cmd_code == 3'd2));
  p_accept_wr_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_write) |=> (cmd_code == 3'd3));
  p_accept_col_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (cmd_addr == AW'($past(req_col))));
endmodule

bind bank_sched bank_sched_chk #(.TW(TW), .CW(CW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_trcd  (cfg_trcd),
  .cfg_tcas  (cfg_tcas),
  .cfg_trp   (cfg_trp),
  .cfg_tras  (cfg_tras),
  .cfg_twr   (cfg_twr),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_col   (req_col),
  .cmd_code  (cmd_code),
  .cmd_addr  (cmd_addr),
  .rd_valid  (rd_valid)
);

// File: tb/sim_bank_sched.sv
module sim_bank_sched;
  localparam int TW = 4, RW = 13, CW = 10, TAGW = 4;
  localparam int AW = (RW > CW) ? RW : CW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst = 1'b1;
  logic [TW-1:0]   cfg_trcd = 4'd3, cfg_tcas = 4'd3, cfg_trp = 4'd3, cfg_tras = 4'd9, cfg_twr = 4'd5;
  logic            req_valid = 1'b0, req_write = 1'b0;
  logic            req_ready;
  logic [RW-1:0]   req_row = '0;
  logic [CW-1:0]   req_col = '0;
  logic [TAGW-1:0] req_tag = '0;
  logic [2:0]      cmd_code;
  logic [AW-1:0]   cmd_addr;
  logic            rd_valid, cfg_warn;
  logic [TAGW-1:0] rd_tag;

  bank_sched #(.TW(TW), .RW(RW), .CW(CW), .TAGW(TAGW)) u0 (
    .clk(clk), .rst(rst),
    .cfg_trcd(cfg_trcd), .cfg_tcas(cfg_tcas), .cfg_trp(cfg_trp),
    .cfg_tras(cfg_tras), .cfg_twr(cfg_twr),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_row(req_row), .req_col(req_col), .req_tag(req_tag),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .cfg_warn(cfg_warn)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Command and read-return log, sampled away from the active edge
  int       lc_cyc  [0:63];
  int       lc_code [0:63];
  int       lc_addr [0:63];
  int       nc;
  int       rv_cyc  [0:15];
  int       rv_tag  [0:15];
  int       nr;

  always @(negedge clk) begin
    if (rst) begin
      nc = 0;
      nr = 0;
    end else begin
      if (cmd_code != 3'd0 && nc < 64) begin
        lc_cyc[nc] = cyc; lc_code[nc] = int'(cmd_code); lc_addr[nc] = int'(cmd_addr);
        nc++;
      end
      if (rd_valid && nr < 16) begin
        rv_cyc[nr] = cyc; rv_tag[nr] = int'(rd_tag);
        nr++;
      end
    end
  end

  int n_tests = 0, n_fail = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cfg %0d/%0d/%0d/%0d/%0d)",
               req, act, exp, cfg_trcd, cfg_tcas, cfg_trp, cfg_tras, cfg_twr);
    end
  endtask

  // Called just after a negedge; returns at a negedge once accepted.
  task automatic send(input bit w, input int row, input int col, input int tag,
                      output bit first_rdy);
    bit done = 1'b0;
    bit first = 1'b1;
    req_valid = 1'b1; req_write = w;
    req_row = RW'(row); req_col = CW'(col); req_tag = TAGW'(tag);
    while (!done) begin
      #1;
      done = req_ready;
      if (first) first_rdy = req_ready;
      first = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic run_cfg(input int trcd, input int tcas, input int trp,
                         input int tras, input int twr);
    int rase, a1, a2, p1, p2;
    bit fr;
    int e_code [0:11] = '{1, 2, 2, 3, 4, 1, 2, 3, 4, 1, 2, 2};
    int e_addr [0:11] = '{5, 1, 2, 3, 0, 9, 4, 5, 0, 2, 6, 7};
    int rd_idx [0:4]  = '{1, 2, 6, 10, 11};
    int rd_tg  [0:4]  = '{1, 2, 4, 6, 7};

    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    cfg_trcd = TW'(trcd); cfg_tcas = TW'(tcas); cfg_trp = TW'(trp);
    cfg_tras = TW'(tras); cfg_twr = TW'(twr);
    repeat (3) @(negedge clk);
    chk("R1 reset cmd_code", int'(cmd_code), 0);
    chk("R1 reset rd_valid", int'(rd_valid), 0);
    rst = 1'b0;
    #1;
    chk("R9 ready without valid", int'(req_ready), 0);
    @(negedge clk);

    rase = imax(tras, trcd + tcas + 2);

    send(1'b0, 5, 1, 1, fr);
    chk("R1 first request waits for ACT", int'(fr), 0);
    send(1'b0, 5, 2, 2, fr);
    chk("R3 back-to-back hit ready", int'(fr), 1);
    send(1'b1, 5, 3, 3, fr);
    send(1'b0, 9, 4, 4, fr);
    chk("R9 miss not ready at once", int'(fr), 0);
    send(1'b1, 9, 5, 5, fr);
    send(1'b0, 2, 6, 6, fr);
    idle(5);
    chk("R9 NOP while idle (cmd count)", nc, 11);
    send(1'b0, 2, 7, 7, fr);
    chk("R3 row kept open, hit ready at once", int'(fr), 1);
    idle(tcas + 4);

    chk("R9 command count", nc, 12);
    if (nc == 12) begin
      for (int i = 0; i < 12; i++) begin
        chk((i == 0) ? "R1 code" : ((i == 4 || i == 8) ? "R5 code" : "R3 code"),
            lc_code[i], e_code[i]);
        chk((i == 0) ? "R1 addr" : "R3 addr", lc_addr[i], e_addr[i]);
      end
      a1 = lc_cyc[0];
      chk("R2 first column", lc_cyc[1], a1 + trcd);
      chk("R3 second read", lc_cyc[2], a1 + trcd + 1);
      chk("R3 write", lc_cyc[3], a1 + trcd + 2);
      p1 = imax(a1 + rase, a1 + trcd + 2 + twr);
      chk((a1 + rase >= a1 + trcd + 2 + twr)
            ? ((tras < trcd + tcas + 2) ? "R8 clamped close" : "R6 close")
            : "R7 close",
          lc_cyc[4], p1);
      chk("R5 reopen", lc_cyc[5], lc_cyc[4] + trp);
      a2 = lc_cyc[5];
      chk("R2 column after reopen", lc_cyc[6], a2 + trcd);
      chk("R3 write after read", lc_cyc[7], a2 + trcd + 1);
      p2 = imax(a2 + rase, a2 + trcd + 1 + twr);
      chk((a2 + rase >= a2 + trcd + 1 + twr) ? "R6 second close" : "R7 second close",
          lc_cyc[8], p2);
      chk("R5 third open", lc_cyc[9], lc_cyc[8] + trp);
      chk("R2 third column", lc_cyc[10], lc_cyc[9] + trcd);

      chk("R4 read count", nr, 5);
      if (nr == 5) begin
        for (int i = 0; i < 5; i++) begin
          chk("R4 read return cycle", rv_cyc[i], lc_cyc[rd_idx[i]] + tcas);
          chk("R4 read return tag", rv_tag[i], rd_tg[i]);
        end
      end
    end
    chk("R8 warn flag", int'(cfg_warn), (tras < trcd + tcas + 2) ? 1 : 0);
  endtask

  initial begin
    int twr_set [0:1]  = '{1, 5};
    int tras_set [0:2] = '{2, 9, 12};
    for (int trcd = 1; trcd <= 3; trcd++)
      for (int tcas = 1; tcas <= 3; tcas++)
        for (int trp = 1; trp <= 3; trp++)
          for (int iw = 0; iw < 2; iw++)
            for (int ir = 0; ir < 3; ir++)
              run_cfg(trcd, tcas, trp, tras_set[ir], twr_set[iw]);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule